// File: doc/BRIEF.md
# SIMT Divergence Lane-Mask Stack

This block tracks which lanes of one SIMD thread may commit results while that thread runs through divergent conditional branches. Every lane steps through every instruction, but only the lanes whose bit is set in the current lane mask write back. The per-lane branch condition, typically taken from each lane's one-bit predicate, arrives together with a control marker. There are three markers: a divergent branch, a switch to the else path, and a reconvergence barrier.

When the active lanes disagree on a branch, the block saves a stack entry. The entry holds the current mask, the condition vector, the else-path PC and the reconvergence PC. The mask then narrows to the lanes that take the branch. The else marker turns the mask to the saved lanes that did not take the branch and reports a redirect to the else path. The reconvergence marker pops the entry and restores the saved mask.

When all active lanes agree, nothing is saved and the branch is reported as uniformly taken or uniformly not taken. The sequencer then must not present the else and reconvergence markers of that branch. Stack overflow and underflow are each reported by a one-cycle error flag, and the state is left untouched. All outputs are registered and change on the clock edge after the marker is presented.

Top module: `div_mask_stack`

## Requirements
- R1: After synchronous reset, lane_mask is all ones, the stack is empty, and every pulse output (diverged, uniform_taken, uniform_not_taken, redirect_valid, overflow_err, underflow_err) is low.
- R2: A branch marker (op_kind = 2'b01) whose condition splits the active lanes saves an entry. On the next edge lane_mask becomes lane_mask AND lane_cond, and diverged pulses for one cycle.
- R3: A branch marker for which every active lane has its condition bit set pushes nothing, leaves lane_mask unchanged, and pulses uniform_taken.
- R4: A branch marker for which no active lane has its condition bit set pushes nothing, leaves lane_mask unchanged, and pulses uniform_not_taken.
- R5: An else marker (op_kind = 2'b10) on a non-empty stack sets lane_mask to saved mask AND NOT saved condition of the top entry. It also pulses redirect_valid with redirect_pc equal to that entry's else PC, and does not pop.
- R6: A reconvergence marker (op_kind = 2'b11) on a non-empty stack restores lane_mask to the top entry's saved mask and pops that entry.
- R7: Entries are restored in last-in first-out order, so nested divergent branches unwind innermost first.
- R8: The stack holds DEPTH entries (default 8). A divergent branch while it is full pulses overflow_err and leaves both lane_mask and the stack unchanged.
- R9: An else or reconvergence marker on an empty stack pulses underflow_err and leaves lane_mask unchanged.
- R10: op_kind = 2'b00 holds lane_mask and the stack, and all pulse outputs are low in the following cycle; at most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | Marker: 00 none, 01 branch, 10 else switch, 11 reconvergence |
| lane_cond | input | LANES | Per-lane branch condition |
| else_pc | input | PC_W | Start of the not-taken path, saved on a divergent branch |
| join_pc | input | PC_W | Reconvergence PC, saved on a divergent branch |
| lane_mask | output | LANES | Lanes allowed to commit results |
| redirect_valid | output | 1 | One-cycle pulse: fetch should jump to redirect_pc |
| redirect_pc | output | PC_W | Target of the path switch |
| diverged | output | 1 | One-cycle pulse: an entry was pushed |
| uniform_taken | output | 1 | One-cycle pulse: all active lanes took the branch |
| uniform_not_taken | output | 1 | One-cycle pulse: no active lane took the branch |
| overflow_err | output | 1 | One-cycle pulse: divergent branch on a full stack |
| underflow_err | output | 1 | One-cycle pulse: else or reconvergence on an empty stack |

## Verification
A branch marker can arrive while the stack is full, so two decisions meet in the same cycle: the uniform check and the overflow check. The bench fills all eight entries with divergent branches. It then presents one more divergent branch, which must raise overflow_err and keep the mask. After that it presents a uniform branch, which must report uniform_taken with overflow_err low, because a uniform branch never needs an entry. A reference model in the bench predicts every cycle's outputs, and the eight pops that follow must return the saved masks in reverse order.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_BRANCH = 2'b01,
    OP_ELSE   = 2'b10,
    OP_JOIN   = 2'b11
  } div_op_e;
endpackage

// File: rtl/div_branch_eval.sv
// Classifies a branch against the current active lanes.
module div_branch_eval #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] act_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] taken_mask,
  output logic             all_taken,
  output logic             none_taken
);
  always_comb begin
    taken_mask = act_mask & cond;
    all_taken  = (taken_mask == act_mask);
    none_taken = (taken_mask == '0) && !all_taken;
  end
endmodule

// File: rtl/div_stack_mem.sv
// Small entry store: synchronous write, asynchronous read (LUT RAM).
module div_stack_mem #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/div_mask_stack.sv
module div_mask_stack
  import simt_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_kind,
  input  logic [LANES-1:0] lane_cond,
  input  logic [PC_W-1:0]  else_pc,
  input  logic [PC_W-1:0]  join_pc,
  output logic [LANES-1:0] lane_mask,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             diverged,
  output logic             uniform_taken,
  output logic             uniform_not_taken,
  output logic             overflow_err,
  output logic             underflow_err
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = 2 * LANES + 2 * PC_W;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  typedef struct packed {
    logic [LANES-1:0] saved;
    logic [LANES-1:0] cond;
    logic [PC_W-1:0]  else_pc;
    logic [PC_W-1:0]  join_pc;
  } entry_t;

  div_op_e          op;
  logic [PTR_W-1:0] depth_q, depth_d;
  logic [LANES-1:0] mask_d;
  logic [PC_W-1:0]  rpc_d;
  logic             rv_d, div_d, ut_d, un_d, ovf_d, unf_d;
  logic             push;
  logic             empty, full;
  logic [LANES-1:0] taken_mask;
  logic             all_taken, none_taken;
  entry_t           top_ent, new_ent;
  logic [ENT_W-1:0] rd_raw;
  logic [AW-1:0]    wr_addr, rd_addr;

  assign op      = div_op_e'(op_kind);
  assign empty   = (depth_q == '0);
  assign full    = (depth_q == FULL_CNT);
  assign wr_addr = AW'(depth_q);
  assign rd_addr = AW'(depth_q - 1'b1);
  assign top_ent = entry_t'(rd_raw);

  always_comb begin
    new_ent.saved   = lane_mask;
    new_ent.cond    = lane_cond;
    new_ent.else_pc = else_pc;
    new_ent.join_pc = join_pc;
  end

  div_branch_eval #(.LANES(LANES)) u_eval (
    .act_mask   (lane_mask),
    .cond       (lane_cond),
    .taken_mask (taken_mask),
    .all_taken  (all_taken),
    .none_taken (none_taken)
  );

  div_stack_mem #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (push),
    .wr_addr (wr_addr),
    .wr_data (ENT_W'(new_ent)),
    .rd_addr (rd_addr),
    .rd_data (rd_raw)
  );

  always_comb begin
    mask_d  = lane_mask;
    depth_d = depth_q;
    rpc_d   = redirect_pc;
    push    = 1'b0;
    rv_d    = 1'b0;
    div_d   = 1'b0;
    ut_d    = 1'b0;
    un_d    = 1'b0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    unique case (op)
      OP_BRANCH: begin
        if (all_taken)       ut_d = 1'b1;
        else if (none_taken) un_d = 1'b1;
        else if (full)       ovf_d = 1'b1;
        else begin
          push    = 1'b1;
          depth_d = depth_q + 1'b1;
          mask_d  = taken_mask;
          div_d   = 1'b1;
        end
      end
      OP_ELSE: begin
        if (empty) unf_d = 1'b1;
        else begin
          mask_d = top_ent.saved & ~top_ent.cond;
          rv_d   = 1'b1;
          rpc_d  = top_ent.else_pc;
        end
      end
      OP_JOIN: begin
        if (empty) unf_d = 1'b1;
        else begin
          mask_d  = top_ent.saved;
          depth_d = depth_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_mask         <= '1;
      depth_q           <= '0;
      redirect_pc       <= '0;
      redirect_valid    <= 1'b0;
      diverged          <= 1'b0;
      uniform_taken     <= 1'b0;
      uniform_not_taken <= 1'b0;
      overflow_err      <= 1'b0;
      underflow_err     <= 1'b0;
    end else begin
      lane_mask         <= mask_d;
      depth_q           <= depth_d;
      redirect_pc       <= rpc_d;
      redirect_valid    <= rv_d;
      diverged          <= div_d;
      uniform_taken     <= ut_d;
      uniform_not_taken <= un_d;
      overflow_err      <= ovf_d;
      underflow_err     <= unf_d;
    end
  end
endmodule

// File: rtl/div_mask_stack_chk.sv
module div_mask_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op_kind,
  input logic [LANES-1:0] lane_mask,
  input logic [PTR_W-1:0] depth_q,
  input logic             redirect_valid,
  input logic             diverged,
  input logic             uniform_taken,
  input logic             uniform_not_taken,
  input logic             overflow_err,
  input logic             underflow_err
);
  // R2
  diverge_src_chk: assert property (@(posedge clk) disable iff (rst)
    diverged |-> ($past(op_kind) == 2'b01) && ((lane_mask & ~$past(lane_mask)) == '0)
                 && (depth_q == $past(depth_q) + 1'b1));

  // R3
  uniform_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (uniform_taken || uniform_not_taken) |-> (lane_mask == $past(lane_mask)) && $stable(depth_q));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_err |-> (lane_mask == $past(lane_mask)) && (depth_q == PTR_W'(DEPTH)));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth_q <= PTR_W'(DEPTH));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_err |-> (lane_mask == $past(lane_mask)) && (depth_q == '0));

  // R10
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect_valid, diverged, uniform_taken, uniform_not_taken, overflow_err, underflow_err}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_kind) == 2'b00) |-> (lane_mask == $past(lane_mask)) && (depth_q == $past(depth_q)));
endmodule

bind div_mask_stack div_mask_stack_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .PTR_W(PTR_W)
) u_chk (
  .clk               (clk),
  .rst               (rst),
  .op_kind           (op_kind),
  .lane_mask         (lane_mask),
  .depth_q           (depth_q),
  .redirect_valid    (redirect_valid),
  .diverged          (diverged),
  .uniform_taken     (uniform_taken),
  .uniform_not_taken (uniform_not_taken),
  .overflow_err      (overflow_err),
  .underflow_err     (underflow_err)
);

// File: tb/div_mask_stack_tb.sv
`timescale 1ns/1ps
module div_mask_stack_tb;
  localparam int LANES = 32;
  localparam int DEPTH = 8;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       op_kind = 2'b00;
  logic [LANES-1:0] lane_cond = '0;
  logic [PC_W-1:0]  else_pc = '0;
  logic [PC_W-1:0]  join_pc = '0;
  logic [LANES-1:0] lane_mask;
  logic             redirect_valid, diverged, uniform_taken, uniform_not_taken;
  logic             overflow_err, underflow_err;
  logic [PC_W-1:0]  redirect_pc;

  always #2 clk = ~clk;

  div_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .op_kind(op_kind), .lane_cond(lane_cond),
    .else_pc(else_pc), .join_pc(join_pc), .lane_mask(lane_mask),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .diverged(diverged), .uniform_taken(uniform_taken),
    .uniform_not_taken(uniform_not_taken), .overflow_err(overflow_err),
    .underflow_err(underflow_err)
  );

  typedef struct {
    logic [LANES-1:0] mask;
    logic [PC_W-1:0]  rpc;
    logic [6:0]       flags; // rv, div, ut, un, ovf, unf, spare
    string            req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  logic [LANES-1:0] m_mask = '1;
  int               m_depth = 0;
  logic [LANES-1:0] m_saved [DEPTH];
  logic [LANES-1:0] m_cond  [DEPTH];
  logic [PC_W-1:0]  m_else  [DEPTH];

  function automatic logic [6:0] pulses();
    return {redirect_valid, diverged, uniform_taken, uniform_not_taken,
            overflow_err, underflow_err, 1'b0};
  endfunction

  task automatic drive(input logic [1:0] k, input logic [LANES-1:0] c,
                       input logic [PC_W-1:0] ep, input logic [PC_W-1:0] jp,
                       input string req);
    exp_t e;
    logic [LANES-1:0] t;
    @(negedge clk);
    op_kind = k; lane_cond = c; else_pc = ep; join_pc = jp;
    e.flags = '0; e.rpc = '0; e.req = req;
    t = m_mask & c;
    case (k)
      2'b01: begin
        if (t == m_mask) e.flags[4] = 1'b1;
        else if (t == '0) e.flags[3] = 1'b1;
        else if (m_depth == DEPTH) e.flags[2] = 1'b1;
        else begin
          m_saved[m_depth] = m_mask; m_cond[m_depth] = c; m_else[m_depth] = ep;
          m_depth++; m_mask = t; e.flags[5] = 1'b1;
        end
      end
      2'b10: begin
        if (m_depth == 0) e.flags[1] = 1'b1;
        else begin
          m_mask = m_saved[m_depth-1] & ~m_cond[m_depth-1];
          e.flags[6] = 1'b1; e.rpc = m_else[m_depth-1];
        end
      end
      2'b11: begin
        if (m_depth == 0) e.flags[1] = 1'b1;
        else begin
          m_depth--; m_mask = m_saved[m_depth];
        end
      end
      default: ;
    endcase
    e.mask = m_mask;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lane_mask !== e.mask) begin
          errors++;
          $display("FAIL %s lane_mask actual %h expected %h", e.req, lane_mask, e.mask);
        end
        checks++;
        if (pulses() !== e.flags) begin
          errors++;
          $display("FAIL %s pulses actual %b expected %b", e.req, pulses(), e.flags);
        end
        if (e.flags[6]) begin
          checks++;
          if (redirect_pc !== e.rpc) begin
            errors++;
            $display("FAIL %s redirect_pc actual %h expected %h", e.req, redirect_pc, e.rpc);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (lane_mask !== '1 || pulses() !== '0) begin
      errors++;
      $display("FAIL R1 reset actual %h/%b expected %h/%b", lane_mask, pulses(), {LANES{1'b1}}, 7'b0);
    end
    // R1 / R9: empty stack after reset
    drive(2'b11, '0, '0, '0, "R9_join_empty");
    drive(2'b10, '0, '0, '0, "R9_else_empty");
    drive(2'b01, '1, 32'h10, 32'h20, "R3");
    drive(2'b01, '0, 32'h10, 32'h20, "R4");
    drive(2'b01, 32'h0000FFFF, 32'h100, 32'h200, "R2");
    drive(2'b01, 32'hFFFF00F0, 32'h140, 32'h180, "R2_nested");
    drive(2'b00, '0, '0, '0, "R10");
    drive(2'b10, '0, '0, '0, "R5_inner");
    drive(2'b11, '0, '0, '0, "R7_inner");
    drive(2'b10, '0, '0, '0, "R5_outer");
    drive(2'b11, '0, '0, '0, "R6");
    drive(2'b00, '1, '0, '0, "R10_idle");
    // fill the stack: each branch drops one lane
    for (int i = 0; i < DEPTH; i++)
      drive(2'b01, ~(32'h1 << i), 32'h400 + i, 32'h800 + i, "R8_fill");
    drive(2'b01, ~(32'h1 << DEPTH), 32'h4FF, 32'h8FF, "R8_overflow");
    drive(2'b01, '1, 32'h4EE, 32'h8EE, "R3_uniform_full");
    drive(2'b10, '0, '0, '0, "R5_deep");
    for (int i = 0; i < DEPTH; i++)
      drive(2'b11, '0, '0, '0, "R7_unwind");
    drive(2'b11, '0, '0, '0, "R9_after_unwind");
    drive(2'b00, '0, '0, '0, "R10_end");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule